// File: doc/BRIEF.md
# Fixed-point butterfly multiply-round-shift unit

This block is the arithmetic core of a transform butterfly. From two signed operands A and B and a signed coefficient C it forms two results in one pass: the sum (A+B)*C and the difference (A-B)*C. Each result is scaled right by a programmable shift SH with half-up rounding. A caller writes the first result to a destination register and the second result to the register after it. Register access, decode and loop control belong to the caller.

The unit has two modes. In word mode it treats each 64-bit input as one signed number. In lane mode it treats each input as four independent signed 16-bit lanes, which suits 2.14 fixed-point data with SH = 14. Inputs are captured on a clock edge when `in_valid` is high, and the results appear on registered outputs one cycle later.

A two-state output controller tracks whether the output register holds a fresh result:
- ST_EMPTY moves to ST_FULL on an accepted input.
- ST_FULL stays in ST_FULL on another accepted input.
- ST_FULL returns to ST_EMPTY when no input arrives.
- ST_EMPTY stays in ST_EMPTY when no input arrives.

Top module: `bfly_mrs`

## Requirements
- R1: In word mode (`mode` = 0), `res_first` is computed as follows. Let P = ((A+B)*C) mod 2^64, read as a signed 64-bit value. Widen P to 65 bits, add the rounding constant of R4, shift arithmetically right by SH, and keep the low 64 bits.
- R2: In word mode, `res_second` is computed in the same way as R1, with (A-B) in place of (A+B).
- R3: In lane mode (`mode` = 1), lane i occupies bits 16i+15 down to 16i of every operand and of both results, for i = 0 to 3. Each lane's operands are sign-extended from bit 15. The lane computes (A±B)*C exactly, adds the rounding constant of R4, shifts arithmetically right by SH, and is truncated to 16 bits. Nothing carries between lanes.
- R4: The rounding constant is 2^(SH-1) when SH is 1 or more, which makes the result floor(x/2^SH + 0.5). When SH = 0 nothing is added and the product passes unshifted.
- R5: The single 5-bit shift `sh` (0 to 31) applies to both results and to every lane. `mode` selects word or lane processing for each input separately.
- R6: A result appears on `res_first` and `res_second` in the cycle after the edge that accepted `in_valid` = 1. `out_valid` is 1 in exactly those cycles and 0 after any edge with `in_valid` = 0.
- R7: After an edge with `in_valid` = 0, both results keep their previous values, whatever the other inputs do.
- R8: While `rst_n` is 0, `out_valid` is 0 and both results are zero.
- R9: Three identities hold in both modes. If B = 0, the two results are equal. If A = B, `res_second` is zero. If C = 0, both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operands on this edge |
| mode | input | 1 | 0 = one 64-bit word, 1 = four 16-bit lanes |
| sh | input | 5 | Right shift amount with half-up rounding |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| op_c | input | 64 | Coefficient C |
| out_valid | output | 1 | Results were produced by the previous edge |
| res_first | output | 64 | round((A+B)*C >> SH) |
| res_second | output | 64 | round((A-B)*C >> SH) |

## Verification
The bench uses the default build: a 64-bit word split into four 16-bit lanes, with a 5-bit shift. With these values every shift from 0 to 31 is reachable. So is 64-bit product wrap-around in word mode. In lane mode the exact 33-bit lane products can exceed 16 bits, which exposes any carry from one lane into the next. Random vectors of both modes are mixed with the worked 2.14 example, operand pairs that produce rounding ties, and the identity cases B = 0, A = B and C = 0.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int WORD_W = 64;
    localparam int LANE_W = 16;
    localparam int SH_W   = 5;

    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_LANE = 1'b1
    } bfly_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } bfly_state_e;
endpackage

// File: rtl/bfly_lane.sv
// One butterfly lane: (a+b)*c and (a-b)*c with half-up rounding shift.
// WRAP = 1 keeps the product modulo 2^W; WRAP = 0 keeps it exact.
module bfly_lane #(
    parameter int W    = 16,
    parameter int SH_W = 5,
    parameter bit WRAP = 1'b0
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    c,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    first,
    output logic [W-1:0]    second
);
    localparam int PW = WRAP ? W : 2 * W + 1;
    localparam int RW = PW + 1;

    logic [PW-1:0] p_sum;
    logic [PW-1:0] p_dif;

    generate
        if (WRAP) begin : g_wrap
            logic [W-1:0] s_w;
            logic [W-1:0] d_w;
            assign s_w   = a + b;
            assign d_w   = a - b;
            assign p_sum = s_w * c;
            assign p_dif = d_w * c;
        end else begin : g_full
            logic signed [W:0]   s_x;
            logic signed [W:0]   d_x;
            logic signed [2*W:0] s_e;
            logic signed [2*W:0] d_e;
            logic signed [2*W:0] c_e;
            assign s_x   = $signed({a[W-1], a}) + $signed({b[W-1], b});
            assign d_x   = $signed({a[W-1], a}) - $signed({b[W-1], b});
            assign s_e   = {{W{s_x[W]}}, s_x};
            assign d_e   = {{W{d_x[W]}}, d_x};
            assign c_e   = {{(W+1){c[W-1]}}, c};
            assign p_sum = s_e * c_e;
            assign p_dif = d_e * c_e;
        end
    endgenerate

    function automatic logic [W-1:0] rnd_shr(input logic [PW-1:0] p,
                                             input logic [SH_W-1:0] s);
        logic signed [RW-1:0] ext;
        logic signed [RW-1:0] bias;
        logic signed [RW-1:0] res;
        ext  = $signed({p[PW-1], p});
        bias = '0;
        if (s != '0) begin
            bias = $signed({{(RW-1){1'b0}}, 1'b1} << (s - 1'b1));
        end
        res = (ext + bias) >>> s;
        return res[W-1:0];
    endfunction

    always_comb begin
        first  = rnd_shr(p_sum, sh);
        second = rnd_shr(p_dif, sh);
    end
endmodule

// File: rtl/bfly_pack.sv
// Word engine plus packed lane engines, selected by mode.
module bfly_pack
    import bfly_pkg::*;
#(
    parameter int WORD_W = bfly_pkg::WORD_W,
    parameter int LANE_W = bfly_pkg::LANE_W,
    parameter int SH_W   = bfly_pkg::SH_W
) (
    input  bfly_mode_e        mode,
    input  logic [SH_W-1:0]   sh,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] c,
    output logic [WORD_W-1:0] first,
    output logic [WORD_W-1:0] second
);
    localparam int NL = WORD_W / LANE_W;

    logic [WORD_W-1:0] w_first, w_second;
    logic [WORD_W-1:0] l_first, l_second;

    bfly_lane #(.W(WORD_W), .SH_W(SH_W), .WRAP(1'b1)) u_word (
        .a(a), .b(b), .c(c), .sh(sh),
        .first(w_first), .second(w_second)
    );

    generate
        for (genvar i = 0; i < NL; i++) begin : g_lane
            bfly_lane #(.W(LANE_W), .SH_W(SH_W), .WRAP(1'b0)) u_lane (
                .a(a[i*LANE_W +: LANE_W]),
                .b(b[i*LANE_W +: LANE_W]),
                .c(c[i*LANE_W +: LANE_W]),
                .sh(sh),
                .first(l_first[i*LANE_W +: LANE_W]),
                .second(l_second[i*LANE_W +: LANE_W])
            );
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_WORD: begin
                first  = w_first;
                second = w_second;
            end
            MODE_LANE: begin
                first  = l_first;
                second = l_second;
            end
            default: begin
                first  = w_first;
                second = w_second;
            end
        endcase
    end
endmodule

// File: rtl/bfly_mrs.sv
// Butterfly multiply-round-shift unit with registered paired result.
module bfly_mrs
    import bfly_pkg::*;
#(
    parameter int WORD_W = bfly_pkg::WORD_W,
    parameter int LANE_W = bfly_pkg::LANE_W,
    parameter int SH_W   = bfly_pkg::SH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [SH_W-1:0]   sh,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_first,
    output logic [WORD_W-1:0] res_second
);
    bfly_state_e       state, state_nx;
    bfly_mode_e        mode_e;
    logic [WORD_W-1:0] nx_first, nx_second;

    assign mode_e = bfly_mode_e'(mode);

    bfly_pack #(.WORD_W(WORD_W), .LANE_W(LANE_W), .SH_W(SH_W)) u_pack (
        .mode(mode_e), .sh(sh), .a(op_a), .b(op_b), .c(op_c),
        .first(nx_first), .second(nx_second)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_first  <= '0;
            res_second <= '0;
        end else if (in_valid) begin
            res_first  <= nx_first;
            res_second <= nx_second;
        end
    end

    assign out_valid = (state == ST_FULL);
endmodule

// File: rtl/bfly_mrs_chk.sv
module bfly_mrs_chk #(
    parameter int WORD_W = 64,
    parameter int SH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [WORD_W-1:0] op_c,
    input logic              out_valid,
    input logic [WORD_W-1:0] res_first,
    input logic [WORD_W-1:0] res_second
);
    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_first) && $stable(res_second)));
    // R9
    zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_b == '0) |=> (res_first == res_second));
    // R9
    same_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == op_b) |=> (res_second == '0));
    // R9
    zero_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_c == '0) |=> (res_first == '0 && res_second == '0));
    // R8
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (!out_valid || $isunknown(out_valid));
        end
    end
endmodule

bind bfly_mrs bfly_mrs_chk #(.WORD_W(WORD_W), .SH_W(SH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .out_valid(out_valid), .res_first(res_first), .res_second(res_second)
);

// File: tb/tb_bfly_mrs.sv
`timescale 1ns/1ps
module tb_bfly_mrs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [4:0]  sh = '0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0;
    logic        out_valid;
    logic [63:0] res_first, res_second;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bfly_mrs dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .sh(sh),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .res_first(res_first), .res_second(res_second)
    );

    // R1 R2 model: 130-bit exact product, wrapped to 64, rounded in 65 bits
    function automatic logic [63:0] model_word(logic [63:0] a, logic [63:0] b,
                                               logic [63:0] c, logic [4:0] s, bit dif);
        logic signed [129:0] x, p;
        logic signed [64:0]  e;
        x = dif ? ($signed({{66{a[63]}}, a}) - $signed({{66{b[63]}}, b}))
                : ($signed({{66{a[63]}}, a}) + $signed({{66{b[63]}}, b}));
        p = x * $signed({{66{c[63]}}, c});
        e = $signed({p[63], p[63:0]});
        if (s != 0) e = e + (65'sd1 <<< (s - 1));
        e = e >>> s;
        return e[63:0];
    endfunction

    // R3 model: one lane in longint arithmetic
    function automatic logic [15:0] model_lane(logic [15:0] a, logic [15:0] b,
                                               logic [15:0] c, logic [4:0] s, bit dif);
        longint av, bv, cv, p;
        av = longint'($signed(a));
        bv = longint'($signed(b));
        cv = longint'($signed(c));
        p  = (dif ? (av - bv) : (av + bv)) * cv;
        if (s != 0) p = p + (longint'(1) <<< (s - 1));
        p = p >>> s;
        return p[15:0];
    endfunction

    function automatic logic [63:0] model(logic m, logic [63:0] a, logic [63:0] b,
                                          logic [63:0] c, logic [4:0] s, bit dif);
        logic [63:0] r;
        if (!m) return model_word(a, b, c, s, dif);
        for (int i = 0; i < 4; i++)
            r[i*16 +: 16] = model_lane(a[i*16 +: 16], b[i*16 +: 16], c[i*16 +: 16], s, dif);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [4:0] s, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] c,
                         input logic [63:0] ef, input logic [63:0] es, input string tag);
        logic [63:0] hf, hs;
        @(negedge clk);
        mode = m; sh = s; op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R6 out_valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " first"}, res_first, ef);
        chk({tag, " second"}, res_second, es);
        hf = res_first; hs = res_second;
        op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
        op_c = {$urandom, $urandom}; mode = ~m; sh = 5'($urandom);
        @(negedge clk);
        chk({tag, " R6 idle out_valid"}, {63'd0, out_valid}, 64'd0);
        chk({tag, " R7 hold first"}, res_first, hf);
        chk({tag, " R7 hold second"}, res_second, hs);
    endtask

    task automatic apply_m(input logic m, input logic [4:0] s, input logic [63:0] a,
                           input logic [63:0] b, input logic [63:0] c, input string tag);
        apply(m, s, a, b, c, model(m, a, b, c, s, 1'b0), model(m, a, b, c, s, 1'b1), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic        m;
        logic [4:0]  s;
        logic [63:0] a, b, c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 out_valid in reset", {63'd0, out_valid}, 64'd0);
        chk("R8 first in reset", res_first, 64'd0);
        chk("R8 second in reset", res_second, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 out_valid after reset", {63'd0, out_valid}, 64'd0);

        // R1 R2 directed word cases, expected values fixed by hand
        apply(1'b0, 5'd2, 64'h1_0000_0000, 64'd3, 64'h1000_0000,
              64'h0400_0000_0c00_0000, 64'h03ff_ffff_f400_0000, "R1 R2 word sh2");
        apply(1'b0, 5'd1, 64'h1_0000_0000, 64'd3, 64'hf_f000_0000,
              64'hf800_0017_e800_0000, 64'hf7ff_ffe8_1800_0000, "R1 R2 word wrap sh1");
        apply(1'b0, 5'd14, 64'h0a71, 64'he6b8, 64'h2d41,
              64'h0000_0000_0000_aa86, 64'hffff_ffff_ffff_643e, "R1 R2 word sh14");
        apply(1'b0, 5'd0, 64'h0a71, 64'he6b8, 64'h2d41,
              64'h0000_0000_2aa1_7069, 64'hffff_ffff_d90f_96f9, "R4 word sh0");
        // R4 ties round toward plus infinity
        apply(1'b0, 5'd1, 64'd1, 64'd0, 64'd1, 64'd1, 64'd1, "R4 tie +0.5");
        apply(1'b0, 5'd1, 64'hffff_ffff_ffff_ffff, 64'd0, 64'd1, 64'd0, 64'd0, "R4 tie -0.5");
        apply(1'b0, 5'd0, 64'd5, 64'd2, 64'd3, 64'd21, 64'd9, "R4 sh0 exact");
        // R3 R5 lane example in 2.14 format
        apply(1'b1, 5'd14, 64'h1000_2000_3000_4000, 64'h1234_fedc_3456_edcb,
              64'h2d41_2d41_2d41_2d41, 64'h182f_15d2_46f2_2061, 64'hfe71_176f_fcef_3a21,
              "R3 R5 lane q2.14");
        apply(1'b1, 5'd1, 64'h0001_0001_ffff_0001, 64'd0, 64'h0001_0001_0001_0001,
              64'h0001_0001_0000_0001, 64'h0001_0001_0000_0001, "R3 R4 lane ties");
        // R3 lane overflow does not leak into neighbour lanes
        apply_m(1'b1, 5'd0, 64'h7fff_7fff_7fff_7fff, 64'h7fff_7fff_7fff_7fff,
                64'h7fff_8000_7fff_8000, "R3 lane no carry");
        apply_m(1'b1, 5'd31, 64'h8000_8000_8000_8000, 64'h8000_7fff_8000_7fff,
                64'h8000_8000_8000_8000, "R3 R5 lane sh31");
        apply_m(1'b0, 5'd31, 64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff,
                64'hffff_ffff_ffff_ffff, "R1 R2 word sh31");
        // R9 identities
        apply_m(1'b0, 5'd7, 64'h1234_5678_9abc_def0, 64'd0, 64'h0fed_cba9, "R9 b zero");
        apply_m(1'b1, 5'd3, 64'h1234_8765_4321_abcd, 64'h1234_8765_4321_abcd, 64'h7777_1111_8888_9999, "R9 a eq b");
        apply_m(1'b0, 5'd5, 64'hdead_beef_0bad_f00d, 64'h0123_4567_89ab_cdef, 64'd0, "R9 c zero");

        // R1 R2 R3 R5 random mix
        for (int k = 0; k < 400; k++) begin
            m = 1'($urandom);
            s = 5'($urandom);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            if (k % 17 == 3) b = '0;
            if (k % 19 == 5) b = a;
            if (k % 23 == 7) c = '0;
            apply_m(m, s, a, b, c, m ? "R3 R5 random lane" : "R1 R2 random word");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule